// File: doc/BRIEF.md
# Burst-Capable AXI4 Register Slave

This block is a full AXI4 slave that serves a small bank of 32-bit registers. Multi-beat INCR bursts are accepted on both the read and the write side. Each beat advances the target address by four bytes. Writes merge in only the byte lanes enabled by the write strobe. All bursts are taken as INCR with a 32-bit beat size, so the size and burst-type fields are not ports of the block.

Any beat that falls outside the register window gets a decode error. A read beat returns DECERR with zero data. A write burst reports DECERR in its single write response if even one of its beats missed the window. The low bits of the first register drive an LED output. Five wrapping counters, one per AXI channel, count handshakes and are exposed on a sideband port for debug.

The read and write sides run independently. Each side holds at most one transaction in flight.

Top module: `axi_burst_regs`

## Requirements
- R1: After synchronous reset, registers 0 to 6 read as zero, all five counters are zero, `led` is 0, BVALID and RVALID are low, and AWREADY and ARREADY are high.
- R2: Register i (0 to 6) sits at byte offset 4*i. A full-strobe write to it is returned unchanged by a later read with RRESP=2'b00.
- R3: Register 7 (offset 0x1C) always reads 0x5EA10007. A write to it completes with BRESP=2'b00 and leaves it unchanged.
- R4: `led` equals bits 3:0 of register 0 at all times.
- R5: Write strobe bit k enables data bits 8k+7:8k. Lanes whose strobe bit is clear keep their previous contents.
- R6: In an INCR burst, beat i addresses the start address plus 4*i, on both the write side and the read side.
- R7: A read burst returns ARLEN+1 beats. RLAST is high only on the final beat, and RID equals the accepted ARID on every beat.
- R8: A read beat at a byte address of 0x20 or higher returns RRESP=2'b11 and data 0. An in-range beat returns 2'b00. The response codes are decided per beat, so a burst may mix them.
- R9: A write burst gets exactly one B response, issued after the beat with WLAST is accepted. BID equals AWID. BRESP is 2'b11 if any beat was out of range and 2'b00 otherwise. Out-of-range beats modify no register.
- R10: AWREADY stays low from the AW handshake until the B handshake completes. ARREADY stays low from the AR handshake until the final R handshake completes.
- R11: `dbg_counts` holds five CNT_W-bit counters, from least significant slice upward: AW, W, B, AR, R. Each counter adds one per handshake on its channel and wraps modulo 2^CNT_W.
- R12: When a read beat and a write beat to the same register are handshaken on the same clock edge, the read beat carries the value the register held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awid | input | ID_W | Write address ID |
| s_awaddr | input | ADDR_W | Write burst start byte address |
| s_awlen | input | 8 | Write beats minus one |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Byte lane enables |
| s_wlast | input | 1 | Final write beat |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bid | output | ID_W | Write response ID |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_arid | input | ID_W | Read address ID |
| s_araddr | input | ADDR_W | Read burst start byte address |
| s_arlen | input | 8 | Read beats minus one |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rid | output | ID_W | Read data ID |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rlast | output | 1 | Final read beat |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| led | output | LED_W | Low bits of register 0 |
| dbg_counts | output | 5*CNT_W | Packed per-channel handshake counters |

## Verification
Because the two sides run independently, a read beat and a write beat can be handshaken on the same edge and aim at the same register. The bench provokes this by opening both bursts at the same address while holding RREADY and WVALID low. It then raises both together, so that both handshakes land on one edge. It judges the result by sampling RDATA just before that edge, where the old contents are expected. A later read must then return the new value.

// File: rtl/axi_regs_pkg.sv
package axi_regs_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned STRB_W = REG_W / 8;
    localparam int unsigned IDX_W  = 8;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_DECERR = 2'b11;

    // channel order inside the packed counter vector
    localparam int unsigned N_CHAN = 5;
    localparam int unsigned CH_AW  = 0;
    localparam int unsigned CH_W   = 1;
    localparam int unsigned CH_B   = 2;
    localparam int unsigned CH_AR  = 3;
    localparam int unsigned CH_R   = 4;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [REG_W-1:0]  data;
        logic [STRB_W-1:0] strb;
    } reg_wr_t;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_DATA,
        WS_RESP
    } wr_state_e;

    typedef enum logic {
        RS_IDLE,
        RS_DATA
    } rd_state_e;

    function automatic logic [REG_W-1:0] merge_lanes(
        input logic [REG_W-1:0]  old_v,
        input logic [REG_W-1:0]  new_v,
        input logic [STRB_W-1:0] strb
    );
        logic [REG_W-1:0] res;
        res = old_v;
        for (int b = 0; b < int'(STRB_W); b++) begin
            if (strb[b]) res[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return res;
    endfunction

    function automatic logic in_window(
        input logic [31:0] byte_addr,
        input int unsigned nregs
    );
        return byte_addr < (nregs * 4);
    endfunction

endpackage

// File: rtl/axi_regs_wr.sv
module axi_regs_wr
    import axi_regs_pkg::*;
#(
    parameter int unsigned ID_W   = 4,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned NREGS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   awid,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic [7:0]        awlen,
    input  logic              awvalid,
    output logic              awready,
    input  logic [REG_W-1:0]  wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wlast,
    input  logic              wvalid,
    output logic              wready,
    output logic [ID_W-1:0]   bid,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output reg_wr_t           wr_req
);

    wr_state_e         st_q;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        len_q;
    logic [8:0]        beat_q;
    logic              err_q;
    logic              beat_ok;
    logic              beat_take;

    assign awready   = (st_q == WS_IDLE);
    assign wready    = (st_q == WS_DATA);
    assign bvalid    = (st_q == WS_RESP);
    assign bid       = id_q;
    assign bresp     = err_q ? RESP_DECERR : RESP_OKAY;
    assign beat_take = wvalid && wready;
    assign beat_ok   = in_window(32'(addr_q), NREGS);

    // beats past the announced length are absorbed without effect
    always_comb begin
        wr_req.en   = beat_take && beat_ok && (beat_q <= {1'b0, len_q});
        wr_req.idx  = IDX_W'(addr_q[ADDR_W-1:2]);
        wr_req.data = wdata;
        wr_req.strb = wstrb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WS_IDLE;
            id_q   <= '0;
            addr_q <= '0;
            len_q  <= '0;
            beat_q <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (st_q)
                WS_IDLE: begin
                    if (awvalid) begin
                        id_q   <= awid;
                        addr_q <= awaddr;
                        len_q  <= awlen;
                        beat_q <= '0;
                        err_q  <= 1'b0;
                        st_q   <= WS_DATA;
                    end
                end
                WS_DATA: begin
                    if (beat_take) begin
                        if (!beat_ok) err_q <= 1'b1;
                        addr_q <= addr_q + ADDR_W'(4);
                        beat_q <= beat_q + 9'd1;
                        if (wlast) st_q <= WS_RESP;
                    end
                end
                WS_RESP: begin
                    if (bready) st_q <= WS_IDLE;
                end
                default: st_q <= WS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/axi_regs_rd.sv
module axi_regs_rd
    import axi_regs_pkg::*;
#(
    parameter int unsigned ID_W   = 4,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned NREGS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   arid,
    input  logic [ADDR_W-1:0] araddr,
    input  logic [7:0]        arlen,
    input  logic              arvalid,
    output logic              arready,
    output logic [ID_W-1:0]   rid,
    output logic [REG_W-1:0]  rdata,
    output logic [1:0]        rresp,
    output logic              rlast,
    output logic              rvalid,
    input  logic              rready,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [REG_W-1:0]  rd_data
);

    rd_state_e         st_q;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        len_q;
    logic [7:0]        beat_q;
    logic              beat_ok;

    assign beat_ok = in_window(32'(addr_q), NREGS);
    assign arready = (st_q == RS_IDLE);
    assign rvalid  = (st_q == RS_DATA);
    assign rid     = id_q;
    assign rlast   = (beat_q == len_q);
    assign rresp   = beat_ok ? RESP_OKAY : RESP_DECERR;
    assign rd_idx  = IDX_W'(addr_q[ADDR_W-1:2]);
    assign rdata   = beat_ok ? rd_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RS_IDLE;
            id_q   <= '0;
            addr_q <= '0;
            len_q  <= '0;
            beat_q <= '0;
        end else begin
            unique case (st_q)
                RS_IDLE: begin
                    if (arvalid) begin
                        id_q   <= arid;
                        addr_q <= araddr;
                        len_q  <= arlen;
                        beat_q <= '0;
                        st_q   <= RS_DATA;
                    end
                end
                RS_DATA: begin
                    if (rready) begin
                        if (rlast) begin
                            st_q <= RS_IDLE;
                        end else begin
                            addr_q <= addr_q + ADDR_W'(4);
                            beat_q <= beat_q + 8'd1;
                        end
                    end
                end
                default: st_q <= RS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/axi_regs_bank.sv
module axi_regs_bank
    import axi_regs_pkg::*;
#(
    parameter int unsigned      NREGS    = 8,
    parameter int unsigned      LED_W    = 4,
    parameter logic [REG_W-1:0] RO_VALUE = 32'h5EA1_0007
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          wr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [REG_W-1:0] rd_data,
    output logic [LED_W-1:0] led
);

    localparam int unsigned N_RW = NREGS - 1;

    logic [REG_W-1:0] rw_q [N_RW];

    for (genvar g = 0; g < int'(N_RW); g++) begin : g_rw
        always_ff @(posedge clk) begin
            if (rst) begin
                rw_q[g] <= '0;
            end else if (wr.en && (wr.idx == IDX_W'(g))) begin
                rw_q[g] <= merge_lanes(rw_q[g], wr.data, wr.strb);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < int'(N_RW); i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = rw_q[i];
        end
        if (rd_idx == IDX_W'(N_RW)) rd_data = RO_VALUE;
    end

    assign led = rw_q[0][LED_W-1:0];

endmodule

// File: rtl/axi_regs_cnt.sv
module axi_regs_cnt
    import axi_regs_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_CHAN-1:0]         hs,
    output logic [N_CHAN*CNT_W-1:0]   counts
);

    for (genvar c = 0; c < int'(N_CHAN); c++) begin : g_ch
        logic [CNT_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)        q <= '0;
            else if (hs[c]) q <= q + CNT_W'(1);
        end
        assign counts[c*CNT_W +: CNT_W] = q;
    end

endmodule

// File: rtl/axi_burst_regs.sv
module axi_burst_regs
    import axi_regs_pkg::*;
#(
    parameter int unsigned      ID_W     = 4,
    parameter int unsigned      ADDR_W   = 12,
    parameter int unsigned      NREGS    = 8,
    parameter int unsigned      LED_W    = 4,
    parameter int unsigned      CNT_W    = 8,
    parameter logic [REG_W-1:0] RO_VALUE = 32'h5EA1_0007
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ID_W-1:0]          s_awid,
    input  logic [ADDR_W-1:0]        s_awaddr,
    input  logic [7:0]               s_awlen,
    input  logic                     s_awvalid,
    output logic                     s_awready,
    input  logic [31:0]              s_wdata,
    input  logic [3:0]               s_wstrb,
    input  logic                     s_wlast,
    input  logic                     s_wvalid,
    output logic                     s_wready,
    output logic [ID_W-1:0]          s_bid,
    output logic [1:0]               s_bresp,
    output logic                     s_bvalid,
    input  logic                     s_bready,
    input  logic [ID_W-1:0]          s_arid,
    input  logic [ADDR_W-1:0]        s_araddr,
    input  logic [7:0]               s_arlen,
    input  logic                     s_arvalid,
    output logic                     s_arready,
    output logic [ID_W-1:0]          s_rid,
    output logic [31:0]              s_rdata,
    output logic [1:0]               s_rresp,
    output logic                     s_rlast,
    output logic                     s_rvalid,
    input  logic                     s_rready,
    output logic [LED_W-1:0]         led,
    output logic [5*CNT_W-1:0]       dbg_counts
);

    reg_wr_t          wr_req;
    logic [IDX_W-1:0] rd_idx;
    logic [REG_W-1:0] rd_data;
    logic [N_CHAN-1:0] hs;

    axi_regs_wr #(.ID_W(ID_W), .ADDR_W(ADDR_W), .NREGS(NREGS)) u_wr (
        .clk(clk), .rst(rst),
        .awid(s_awid), .awaddr(s_awaddr), .awlen(s_awlen),
        .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wlast(s_wlast),
        .wvalid(s_wvalid), .wready(s_wready),
        .bid(s_bid), .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .wr_req(wr_req)
    );

    axi_regs_rd #(.ID_W(ID_W), .ADDR_W(ADDR_W), .NREGS(NREGS)) u_rd (
        .clk(clk), .rst(rst),
        .arid(s_arid), .araddr(s_araddr), .arlen(s_arlen),
        .arvalid(s_arvalid), .arready(s_arready),
        .rid(s_rid), .rdata(s_rdata), .rresp(s_rresp), .rlast(s_rlast),
        .rvalid(s_rvalid), .rready(s_rready),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    axi_regs_bank #(.NREGS(NREGS), .LED_W(LED_W), .RO_VALUE(RO_VALUE)) u_bank (
        .clk(clk), .rst(rst),
        .wr(wr_req), .rd_idx(rd_idx), .rd_data(rd_data), .led(led)
    );

    assign hs[CH_AW] = s_awvalid && s_awready;
    assign hs[CH_W]  = s_wvalid  && s_wready;
    assign hs[CH_B]  = s_bvalid  && s_bready;
    assign hs[CH_AR] = s_arvalid && s_arready;
    assign hs[CH_R]  = s_rvalid  && s_rready;

    axi_regs_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .hs(hs), .counts(dbg_counts)
    );

endmodule

// File: rtl/axi_regs_chk.sv
module axi_regs_chk #(
    parameter int unsigned ID_W  = 4,
    parameter int unsigned LED_W = 4,
    parameter int unsigned CNT_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               awvalid,
    input logic               awready,
    input logic               wvalid,
    input logic               wready,
    input logic               wlast,
    input logic               bvalid,
    input logic               arvalid,
    input logic               arready,
    input logic               rvalid,
    input logic               rready,
    input logic               rlast,
    input logic [1:0]         rresp,
    input logic [31:0]        rdata,
    input logic [ID_W-1:0]    rid,
    input logic [LED_W-1:0]   led,
    input logic [5*CNT_W-1:0] counts
);

    logic [CNT_W-1:0] c_aw;
    logic [CNT_W-1:0] c_r;
    assign c_aw = counts[0 +: CNT_W];
    assign c_r  = counts[4*CNT_W +: CNT_W];

    // R4: the LED pins move only after a write beat was taken
    a_r4_led_follows_write: assert property (@(posedge clk) disable iff (rst)
        !$past(wvalid && wready) |-> $stable(led));

    // R7: a stalled read beat keeps its payload
    a_r7_rbeat_held: assert property (@(posedge clk) disable iff (rst)
        rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rlast)
                              && $stable(rresp) && $stable(rid));

    // R8: only OKAY or DECERR appear on the read channel
    a_r8_resp_code: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (rresp == 2'b00 || rresp == 2'b11));

    // R9: a write response appears only right after the last data beat
    a_r9_b_after_wlast: assert property (@(posedge clk) disable iff (rst)
        $rose(bvalid) |-> $past(wvalid && wready && wlast));

    // R10: one outstanding burst per direction
    a_r10_aw_blocked: assert property (@(posedge clk) disable iff (rst)
        bvalid |-> !awready);
    a_r10_ar_blocked: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> !arready);

    // R11: counters step by exactly the handshakes seen
    a_r11_aw_count: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> c_aw == $past(c_aw) + CNT_W'($past(awvalid && awready)));
    a_r11_r_count: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> c_r == $past(c_r) + CNT_W'($past(rvalid && rready)));

endmodule

bind axi_burst_regs axi_regs_chk #(.ID_W(ID_W), .LED_W(LED_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst),
    .awvalid(s_awvalid), .awready(s_awready),
    .wvalid(s_wvalid), .wready(s_wready), .wlast(s_wlast),
    .bvalid(s_bvalid),
    .arvalid(s_arvalid), .arready(s_arready),
    .rvalid(s_rvalid), .rready(s_rready), .rlast(s_rlast),
    .rresp(s_rresp), .rdata(s_rdata), .rid(s_rid),
    .led(led), .counts(dbg_counts)
);

// File: tb/axi_burst_regs_bench.sv
`timescale 1ns/1ps
module axi_burst_regs_bench;

    localparam int CW = 8;
    localparam logic [31:0] ROV = 32'h5EA1_0007;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  s_awid = '0;
    logic [11:0] s_awaddr = '0;
    logic [7:0]  s_awlen = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wlast = 1'b0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [3:0]  s_bid;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b0;
    logic [3:0]  s_arid = '0;
    logic [11:0] s_araddr = '0;
    logic [7:0]  s_arlen = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [3:0]  s_rid;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rlast;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic [3:0]  led;
    logic [5*CW-1:0] dbg_counts;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int n_aw = 0, n_w = 0, n_b = 0, n_ar = 0, n_r = 0;
    logic [31:0] rdbuf [16];
    logic [1:0]  rrbuf [16];

    always #2.5 clk = ~clk;

    axi_burst_regs u_axi_burst_regs (.*);

    typedef struct packed {
        logic        rd;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [31:0] exp;
        logic [1:0]  resp;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{1'b0, 12'h004, 32'h1122_3344, 4'hF, 32'h0, 2'b00},
        '{1'b1, 12'h004, 32'h0, 4'h0, 32'h1122_3344, 2'b00},
        '{1'b0, 12'h004, 32'hAABB_CCDD, 4'b0001, 32'h0, 2'b00},
        '{1'b1, 12'h004, 32'h0, 4'h0, 32'h1122_33DD, 2'b00},
        '{1'b0, 12'h004, 32'hAABB_CCDD, 4'b1100, 32'h0, 2'b00},
        '{1'b1, 12'h004, 32'h0, 4'h0, 32'hAABB_33DD, 2'b00},
        '{1'b0, 12'h01C, 32'hFFFF_FFFF, 4'hF, 32'h0, 2'b00},
        '{1'b1, 12'h01C, 32'h0, 4'h0, ROV, 2'b00},
        '{1'b1, 12'h020, 32'h0, 4'h0, 32'h0, 2'b11},
        '{1'b0, 12'h040, 32'h1234_5678, 4'hF, 32'h0, 2'b11},
        '{1'b1, 12'h018, 32'h0, 4'h0, 32'h0, 2'b00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_burst(input logic [11:0] a, input int n, input logic [31:0] d0,
                            input logic [3:0] s, input logic [3:0] id, output logic [1:0] resp);
        @(negedge clk);
        s_awid = id; s_awaddr = a; s_awlen = 8'(n - 1); s_awvalid = 1'b1;
        while (!s_awready) @(negedge clk);
        @(negedge clk);
        s_awvalid = 1'b0; n_aw++;
        chk("R10 awready low during write", 32'(s_awready), 32'd0);
        for (int i = 0; i < n; i++) begin
            s_wdata = d0 + 32'(i); s_wstrb = s; s_wlast = (i == n - 1); s_wvalid = 1'b1;
            while (!s_wready) @(negedge clk);
            @(negedge clk);
            n_w++;
        end
        s_wvalid = 1'b0; s_wlast = 1'b0; s_bready = 1'b1;
        while (!s_bvalid) @(negedge clk);
        resp = s_bresp;
        chk("R9 bid echoes awid", 32'(s_bid), 32'(id));
        @(negedge clk);
        s_bready = 1'b0; n_b++;
    endtask

    task automatic rd_burst(input logic [11:0] a, input int n, input logic [3:0] id);
        @(negedge clk);
        s_arid = id; s_araddr = a; s_arlen = 8'(n - 1); s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0; n_ar++;
        chk("R10 arready low during read", 32'(s_arready), 32'd0);
        s_rready = 1'b1;
        for (int i = 0; i < n; i++) begin
            while (!s_rvalid) @(negedge clk);
            rdbuf[i] = s_rdata; rrbuf[i] = s_rresp;
            chk("R7 rlast only on final beat", 32'(s_rlast), 32'(i == n - 1));
            chk("R7 rid echoes arid", 32'(s_rid), 32'(id));
            @(negedge clk);
            n_r++;
        end
        s_rready = 1'b0;
        chk("R7 no beat beyond arlen", 32'(s_rvalid), 32'd0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog req=ALL actual=%0d cycles expected<150000", cyc);
            summary();
        end
    end

    initial begin
        logic [1:0]  br;
        logic [CW-1:0] w_before;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R1 awready after reset", 32'(s_awready), 32'd1);
        chk("R1 arready after reset", 32'(s_arready), 32'd1);
        chk("R1 bvalid after reset", 32'(s_bvalid), 32'd0);
        chk("R1 rvalid after reset", 32'(s_rvalid), 32'd0);
        chk("R1 led after reset", 32'(led), 32'd0);
        chk("R1 counters after reset", 32'(dbg_counts), 32'd0);
        rd_burst(12'h000, 8, 4'h1);
        for (int i = 0; i < 8; i++)
            chk("R1 register reset value", rdbuf[i], (i == 7) ? ROV : 32'd0);

        // table of single-beat accesses (R2, R3, R5, R8, R9)
        for (int v = 0; v < 11; v++) begin
            if (VEC[v].rd) begin
                rd_burst(VEC[v].addr, 1, 4'(v));
                chk("R2/R3 table read data", rdbuf[0], VEC[v].exp);
                chk("R8 table read resp", 32'(rrbuf[0]), 32'(VEC[v].resp));
            end else begin
                wr_burst(VEC[v].addr, 1, VEC[v].data, VEC[v].strb, 4'(v), br);
                chk("R9 table write resp", 32'(br), 32'(VEC[v].resp));
            end
        end

        // LED and strobe on register 0
        wr_burst(12'h000, 1, 32'hFFFF_FFF5, 4'hF, 4'h2, br);
        chk("R4 led from reg0", 32'(led), 32'h5);
        wr_burst(12'h000, 1, 32'h0, 4'b1110, 4'h2, br);
        chk("R5 masked lane keeps led", 32'(led), 32'h5);

        // full bank burst
        wr_burst(12'h000, 8, 32'hA000_0000, 4'hF, 4'h3, br);
        chk("R3 burst touching reg7 resp", 32'(br), 32'd0);
        chk("R4 led after burst", 32'(led), 32'h0);
        rd_burst(12'h000, 8, 4'h4);
        for (int i = 0; i < 8; i++)
            chk("R6 burst beat address step", rdbuf[i], (i == 7) ? ROV : 32'hA000_0000 + 32'(i));

        // burst crossing the window end
        wr_burst(12'h018, 4, 32'hC0DE_0000, 4'hF, 4'h5, br);
        chk("R9 crossing write resp", 32'(br), 32'h3);
        rd_burst(12'h018, 4, 4'h6);
        chk("R8 crossing beat0 data", rdbuf[0], 32'hC0DE_0000);
        chk("R8 crossing beat1 data", rdbuf[1], ROV);
        chk("R8 crossing beat2 data", rdbuf[2], 32'h0);
        chk("R8 crossing beat0 resp", 32'(rrbuf[0]), 32'h0);
        chk("R8 crossing beat1 resp", 32'(rrbuf[1]), 32'h0);
        chk("R8 crossing beat2 resp", 32'(rrbuf[2]), 32'h3);
        chk("R8 crossing beat3 resp", 32'(rrbuf[3]), 32'h3);
        rd_burst(12'h000, 1, 4'h7);
        chk("R9 out-of-range beats do not alias", rdbuf[0], 32'hA000_0000);

        // read and write on the same register at the same edge
        @(negedge clk);
        s_arid = 4'h8; s_araddr = 12'h004; s_arlen = 8'd0; s_arvalid = 1'b1;
        s_awid = 4'h9; s_awaddr = 12'h004; s_awlen = 8'd0; s_awvalid = 1'b1;
        @(negedge clk);
        s_arvalid = 1'b0; s_awvalid = 1'b0; n_ar++; n_aw++;
        s_wdata = 32'h600D_0001; s_wstrb = 4'hF; s_wlast = 1'b1; s_wvalid = 1'b1;
        s_rready = 1'b1;
        chk("R12 read beat carries old value", s_rdata, 32'hA000_0001);
        @(negedge clk);
        s_wvalid = 1'b0; s_wlast = 1'b0; s_rready = 1'b0; n_w++; n_r++;
        chk("R12 read burst closed", 32'(s_rvalid), 32'd0);
        s_bready = 1'b1;
        while (!s_bvalid) @(negedge clk);
        @(negedge clk);
        s_bready = 1'b0; n_b++;
        rd_burst(12'h004, 1, 4'hA);
        chk("R12 write landed after collision", rdbuf[0], 32'h600D_0001);

        // counter totals and wrap
        chk("R11 AW count", 32'(dbg_counts[0*CW +: CW]), 32'(n_aw % 256));
        chk("R11 W count", 32'(dbg_counts[1*CW +: CW]), 32'(n_w % 256));
        chk("R11 B count", 32'(dbg_counts[2*CW +: CW]), 32'(n_b % 256));
        chk("R11 AR count", 32'(dbg_counts[3*CW +: CW]), 32'(n_ar % 256));
        chk("R11 R count", 32'(dbg_counts[4*CW +: CW]), 32'(n_r % 256));
        w_before = dbg_counts[1*CW +: CW];
        wr_burst(12'h100, 256, 32'h0, 4'hF, 4'hB, br);
        chk("R9 long out-of-range burst resp", 32'(br), 32'h3);
        chk("R11 W count wraps", 32'(dbg_counts[1*CW +: CW]), 32'(w_before));
        chk("R11 AW count after wrap burst", 32'(dbg_counts[0*CW +: CW]), 32'(n_aw % 256));
        rd_burst(12'h000, 1, 4'hC);
        chk("R9 long burst left reg0", rdbuf[0], 32'hA000_0000);

        summary();
    end

endmodule